// File: doc/BRIEF.md
# Quadrant Path Selector

This block sits in the packet injection path of one tile in a mesh whose cores each have four network interfaces, one to each of the four routers around the core. When a packet starts, the block compares the source and destination core coordinates and places the destination into one of eight direction classes. These are: left, right, up or down along the same row or column, or one of four diagonal quadrants. It then reads the path table entry for that class. The entry names the local interface that injects the packet and the interface at the destination core that receives it. From the two codes the block forms a 4-bit header extension. The extension stays fixed until the packet ends.

A central traffic controller can rewrite the table at any time through a write-only configuration port. When no packet is in flight, a write takes effect on the next clock edge. A write that arrives while a packet is in flight is parked in a per-entry pending slot, and every parked write lands when that packet ends. A packet whose destination equals its source is refused with a one-cycle error pulse.

Top module: `quad_path_sel`

## Requirements
- R1: After reset, valid_o, err_o, class_o and ext_o are all 0.
- R2: class_o uses these codes, with y growing downward: 0 = left (same row, dst x < src x), 1 = right (same row, dst x > src x), 2 = up (same column, dst y < src y), 3 = down (same column, dst y > src y), 4 = upper-right, 5 = lower-right, 6 = lower-left, 7 = upper-left.
- R3: After reset the table holds these defaults, indexed by class code: 0:0111, 1:1101, 2:1110, 3:1011, 4:1100, 5:1001, 6:0011, 7:0110. The interface codes are 11, 10, 00 and 01 for the upper-right, lower-right, lower-left and upper-left interfaces.
- R4: ext_o is {qout_o, qin_o}, with the injection interface code in ext_o[3:2] and the ejection interface code in ext_o[1:0]. All three read 0 while valid_o is low.
- R5: When sop_i is high while valid_o is low and the coordinates differ, valid_o is 1 from the next cycle on. class_o and ext_o then show the class and the table entry as they stood before that edge, and they hold while valid_o stays high.
- R6: When eop_i is high while valid_o is high, valid_o, class_o and ext_o are 0 in the next cycle.
- R7: When sop_i is high while valid_o is low and the source equals the destination, err_o is 1 for exactly the next cycle and valid_o stays 0.
- R8: sop_i has no effect while valid_o is high.
- R9: A configuration write while valid_o is low is seen by a packet that starts one cycle later. A packet that starts in the same cycle as the write still gets the old entry.
- R10: Configuration writes while valid_o is high and eop_i is low do not change ext_o. They land when the packet ends: writes to different entries all land, and for repeated writes to one entry the last one wins.
- R11: A configuration write in the same cycle as eop_i takes effect at that edge, and it overrides any pending write to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start of packet, with coordinates valid |
| eop_i | input | 1 | End of the packet in flight |
| src_x_i | input | COORD_W | Source column |
| src_y_i | input | COORD_W | Source row |
| dst_x_i | input | COORD_W | Destination column |
| dst_y_i | input | COORD_W | Destination row |
| cfg_we_i | input | 1 | Table write enable |
| cfg_idx_i | input | 3 | Table entry (class code) to write |
| cfg_data_i | input | 4 | Entry value {qout, qin} |
| valid_o | output | 1 | Packet in flight with a valid extension |
| err_o | output | 1 | Source equal to destination was refused |
| class_o | output | 3 | Direction class of the packet in flight |
| qout_o | output | 2 | Local injection interface code |
| qin_o | output | 2 | Destination ejection interface code |
| ext_o | output | 4 | Header extension {qout, qin} |

## Verification
The assertions run on every cycle. They check that the extension and the class stay put for as long as a packet is in flight, that a start-of-packet arriving mid-packet changes nothing, that packet end drops valid on the next cycle, and that error and valid never overlap. The bench scenarios are needed for everything that depends on values: the class decode for each of the eight directions, the default entries, and when table writes land, whether before a packet, in the same cycle as a start, deferred during a packet, repeated, or coinciding with packet end.

// File: rtl/quad_path_pkg.sv
package quad_path_pkg;
  localparam int N_CLS = 8;
  localparam int CLS_W = 3;
  localparam int NI_W  = 2;
  localparam int ENT_W = 2 * NI_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_LEFT = 3'd0, CLS_RIGHT = 3'd1, CLS_UP = 3'd2, CLS_DOWN = 3'd3,
    CLS_UR   = 3'd4, CLS_LR    = 3'd5, CLS_LL = 3'd6, CLS_UL   = 3'd7
  } dir_cls_e;

  localparam logic [NI_W-1:0] NI_UR = 2'b11;
  localparam logic [NI_W-1:0] NI_LR = 2'b10;
  localparam logic [NI_W-1:0] NI_LL = 2'b00;
  localparam logic [NI_W-1:0] NI_UL = 2'b01;

  // shortest path: leave toward the destination, enter on the side facing the source
  function automatic logic [ENT_W-1:0] default_entry(input int idx);
    case (idx)
      0:       return {NI_UL, NI_UR};
      1:       return {NI_UR, NI_UL};
      2:       return {NI_UR, NI_LR};
      3:       return {NI_LR, NI_UR};
      4:       return {NI_UR, NI_LL};
      5:       return {NI_LR, NI_UL};
      6:       return {NI_LL, NI_UR};
      default: return {NI_UL, NI_LR};
    endcase
  endfunction
endpackage

// File: rtl/qps_classifier.sv
module qps_classifier
  import quad_path_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output dir_cls_e           cls_o,
  output logic               same_o
);
  logic x_eq, y_eq, x_gt, y_gt;

  assign x_eq   = (dst_x_i == src_x_i);
  assign y_eq   = (dst_y_i == src_y_i);
  assign x_gt   = (dst_x_i > src_x_i);
  assign y_gt   = (dst_y_i > src_y_i);
  assign same_o = x_eq && y_eq;

  always_comb begin
    if (y_eq)      cls_o = x_gt ? CLS_RIGHT : CLS_LEFT;
    else if (x_eq) cls_o = y_gt ? CLS_DOWN : CLS_UP;
    else if (x_gt) cls_o = y_gt ? CLS_LR : CLS_UR;
    else           cls_o = y_gt ? CLS_LL : CLS_UL;
  end
endmodule

// File: rtl/qps_path_table.sv
module qps_path_table
  import quad_path_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CLS_W-1:0] widx_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic             defer_i,
  input  logic [CLS_W-1:0] ridx_i,
  output logic [ENT_W-1:0] rdata_o
);
  logic [ENT_W-1:0] ent_rd [N_CLS];

  for (genvar i = 0; i < N_CLS; i++) begin : g_ent
    logic             hit;
    logic [ENT_W-1:0] ent_q;
    logic             pend_v_q;
    logic [ENT_W-1:0] pend_d_q;

    assign hit       = we_i && (widx_i == CLS_W'(i));
    assign ent_rd[i] = ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q    <= default_entry(i);
        pend_v_q <= 1'b0;
        pend_d_q <= '0;
      end else if (hit && !defer_i) begin
        ent_q    <= wdata_i;
        pend_v_q <= 1'b0;
      end else if (hit) begin
        pend_v_q <= 1'b1;
        pend_d_q <= wdata_i;
      end else if (!defer_i && pend_v_q) begin
        ent_q    <= pend_d_q;
        pend_v_q <= 1'b0;
      end
    end
  end

  assign rdata_o = ent_rd[ridx_i];
endmodule

// File: rtl/quad_path_sel.sv
module quad_path_sel
  import quad_path_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sop_i,
  input  logic               eop_i,
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_idx_i,
  input  logic [3:0]         cfg_data_i,
  output logic               valid_o,
  output logic               err_o,
  output logic [2:0]         class_o,
  output logic [1:0]         qout_o,
  output logic [1:0]         qin_o,
  output logic [3:0]         ext_o
);
  dir_cls_e         cls;
  logic             same;
  logic [ENT_W-1:0] ent;
  logic             busy_q, err_q, take;
  logic [CLS_W-1:0] cls_q;
  logic [ENT_W-1:0] ext_q;

  qps_classifier #(.COORD_W(COORD_W)) u_cls (
    .src_x_i (src_x_i),
    .src_y_i (src_y_i),
    .dst_x_i (dst_x_i),
    .dst_y_i (dst_y_i),
    .cls_o   (cls),
    .same_o  (same)
  );

  // writes park while a packet is in flight, unless it ends this cycle
  qps_path_table u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_data_i),
    .defer_i (busy_q && !eop_i),
    .ridx_i  (cls),
    .rdata_o (ent)
  );

  assign take = sop_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cls_q  <= '0;
      ext_q  <= '0;
    end else begin
      err_q <= take && same;
      if (take && !same) begin
        busy_q <= 1'b1;
        cls_q  <= cls;
        ext_q  <= ent;
      end else if (busy_q && eop_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign valid_o = busy_q;
  assign err_o   = err_q;
  assign class_o = busy_q ? cls_q : '0;
  assign ext_o   = busy_q ? ext_q : '0;
  assign qout_o  = ext_o[3:2];
  assign qin_o   = ext_o[1:0];
endmodule

// File: rtl/quad_path_sel_chk.sv
module quad_path_sel_chk #(
  parameter int COORD_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sop_i,
  input logic               eop_i,
  input logic [COORD_W-1:0] src_x_i,
  input logic [COORD_W-1:0] src_y_i,
  input logic [COORD_W-1:0] dst_x_i,
  input logic [COORD_W-1:0] dst_y_i,
  input logic               valid_o,
  input logic               err_o,
  input logic [2:0]         class_o,
  input logic [3:0]         ext_o
);
  logic same;
  assign same = (src_x_i == dst_x_i) && (src_y_i == dst_y_i);

  // R5
  held_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eop_i) |=> (valid_o && $stable(ext_o) && $stable(class_o)));
  // R5
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !valid_o && !same) |=> valid_o);
  // R6
  end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eop_i) |=> (!valid_o && ext_o == 4'd0));
  // R7
  self_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && !valid_o && same) |=> (err_o && !valid_o));
  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && valid_o));
  // R8
  busy_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sop_i) |=> !err_o);
endmodule

bind quad_path_sel quad_path_sel_chk #(.COORD_W(COORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sop_i   (sop_i),
  .eop_i   (eop_i),
  .src_x_i (src_x_i),
  .src_y_i (src_y_i),
  .dst_x_i (dst_x_i),
  .dst_y_i (dst_y_i),
  .valid_o (valid_o),
  .err_o   (err_o),
  .class_o (class_o),
  .ext_o   (ext_o)
);

// File: tb/quad_path_sel_tb.sv
module quad_path_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sop_i = 0, eop_i = 0, cfg_we_i = 0;
  logic [CW-1:0] src_x_i = 0, src_y_i = 0, dst_x_i = 0, dst_y_i = 0;
  logic [2:0] cfg_idx_i = 0;
  logic [3:0] cfg_data_i = 0;
  logic valid_o, err_o;
  logic [2:0] class_o;
  logic [1:0] qout_o, qin_o;
  logic [3:0] ext_o;

  int checks = 0, failures = 0, cycles = 0;

  quad_path_sel #(.COORD_W(CW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  int m_tbl [8];
  int m_pend [8];      // -1 = none
  bit m_busy, m_err;
  int m_cls, m_ext;

  function automatic int classify(int sx, int sy, int dx, int dy);
    if (sy == dy) return (dx > sx) ? 1 : 0;
    if (sx == dx) return (dy > sy) ? 3 : 2;
    if (dx > sx)  return (dy > sy) ? 5 : 4;
    return (dy > sy) ? 6 : 7;
  endfunction

  task automatic model_reset();
    int defs[8] = '{4'b0111, 4'b1101, 4'b1110, 4'b1011, 4'b1100, 4'b1001, 4'b0011, 4'b0110};
    for (int i = 0; i < 8; i++) begin m_tbl[i] = defs[i]; m_pend[i] = -1; end
    m_busy = 0; m_err = 0; m_cls = 0; m_ext = 0;
  endtask

  initial model_reset();

  always @(posedge clk_i) begin
    if (rst_ni) begin
      int c;
      bit same, deferred;
      int old_tbl[8];
      old_tbl = m_tbl;
      c = classify(src_x_i, src_y_i, dst_x_i, dst_y_i);
      same = (src_x_i == dst_x_i) && (src_y_i == dst_y_i);
      deferred = m_busy && !eop_i;
      if (!deferred)
        for (int i = 0; i < 8; i++)
          if (m_pend[i] >= 0) begin m_tbl[i] = m_pend[i]; m_pend[i] = -1; end
      if (cfg_we_i) begin
        if (deferred) m_pend[cfg_idx_i] = cfg_data_i;
        else begin m_tbl[cfg_idx_i] = cfg_data_i; m_pend[cfg_idx_i] = -1; end
      end
      m_err = sop_i && !m_busy && same;
      if (sop_i && !m_busy && !same) begin
        m_busy = 1; m_cls = c; m_ext = old_tbl[c];
      end else if (m_busy && eop_i) m_busy = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cycles++;
      check("MODEL valid", valid_o, m_busy);
      check("MODEL err", err_o, m_err);
      check("MODEL class", class_o, m_busy ? m_cls : 0);
      check("MODEL ext", ext_o, m_busy ? m_ext : 0);
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic start_pkt(int dx, int dy);
    @(negedge clk_i);
    sop_i = 1; src_x_i = 3; src_y_i = 3; dst_x_i = CW'(dx); dst_y_i = CW'(dy);
    @(negedge clk_i);
    sop_i = 0;
  endtask

  task automatic end_pkt();
    @(negedge clk_i);
    eop_i = 1;
    @(negedge clk_i);
    eop_i = 0;
  endtask

  task automatic cfg_write(int idx, int data);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_data_i = 4'(data);
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  initial begin
    int dx[8] = '{1, 5, 3, 3, 5, 6, 0, 1};
    int dy[8] = '{3, 3, 0, 6, 1, 6, 5, 1};
    int defs[8] = '{4'b0111, 4'b1101, 4'b1110, 4'b1011, 4'b1100, 4'b1001, 4'b0011, 4'b0110};
    #(CLK_PERIOD*2 + 1);
    check("R1 valid", valid_o, 0);
    check("R1 err", err_o, 0);
    check("R1 ext", ext_o, 0);
    check("R1 class", class_o, 0);
    @(negedge clk_i); rst_ni = 1;

    // R2 R3 R4: every class with default entries
    for (int k = 0; k < 8; k++) begin
      start_pkt(dx[k], dy[k]);
      check("R2 class", class_o, k);
      check("R3 default", ext_o, defs[k]);
      check("R4 qout", qout_o, defs[k] >> 2);
      check("R4 qin", qin_o, defs[k] & 3);
      check("R5 valid", valid_o, 1);
      end_pkt();
      check("R6 valid", valid_o, 0);
      check("R6 ext", ext_o, 0);
    end

    // R7 self-addressed
    start_pkt(3, 3);
    check("R7 err", err_o, 1);
    check("R7 valid", valid_o, 0);
    @(negedge clk_i);
    check("R7 pulse", err_o, 0);

    // R8 start during a packet is ignored
    start_pkt(5, 3);
    start_pkt(1, 1);
    check("R8 class", class_o, 1);
    check("R8 ext", ext_o, 4'b1101);
    end_pkt();

    // R9 write then start; write with start in same cycle
    cfg_write(4, 4'h5);
    start_pkt(5, 1);
    check("R9 new", ext_o, 4'h5);
    end_pkt();
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 3'd4; cfg_data_i = 4'h9;
    sop_i = 1; dst_x_i = 5; dst_y_i = 1;
    @(negedge clk_i);
    cfg_we_i = 0; sop_i = 0;
    check("R9 same-cycle old", ext_o, 4'h5);
    end_pkt();
    start_pkt(5, 1);
    check("R9 landed", ext_o, 4'h9);
    end_pkt();

    // R10 deferred writes
    start_pkt(5, 3);
    cfg_write(1, 4'hA);
    cfg_write(0, 4'h3);
    cfg_write(0, 4'h4);
    check("R10 held", ext_o, 4'b1101);
    end_pkt();
    start_pkt(5, 3);
    check("R10 entry1", ext_o, 4'hA);
    end_pkt();
    start_pkt(1, 3);
    check("R10 last wins", ext_o, 4'h4);
    end_pkt();

    // R11 write coincident with packet end
    start_pkt(3, 0);
    cfg_write(2, 4'h1);
    @(negedge clk_i);
    eop_i = 1; cfg_we_i = 1; cfg_idx_i = 3'd2; cfg_data_i = 4'h2;
    @(negedge clk_i);
    eop_i = 0; cfg_we_i = 0;
    check("R11 ended", valid_o, 0);
    start_pkt(3, 0);
    check("R11 override", ext_o, 4'h2);
    end_pkt();

    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule